// File: doc/BRIEF.md
# Interrupt-Triggered Single-Unit Transfer Engine

This block moves one data unit, a byte or a 16-bit word, from a 24-bit source address to a 24-bit destination address each time an interrupt source fires. The CPU first loads a small descriptor file and sets a single transfer-enable bit. An activation runs one read phase and then one write phase on a valid/ready memory port. After that the block updates the transfer counter and decides three things: whether the source's flag is cleared, whether the enable bit is dropped, and whether the CPU is interrupted.

Each descriptor slot has a chain bit. When that bit is set, the next slot's transfer starts directly after the current one, with none of the end-of-transfer bookkeeping. The last slot cannot chain. An activation that arrives while a transfer is running is counted and served later. An activation that arrives while the enable bit is low is left to the CPU and does not touch the engine.

Top module: `xfer_ctl`

## Requirements
- R1: The source and destination address registers of each slot hold 24 bits. They read back as written through `cfg_rdata` (select 0 = source, 1 = destination).
- R2: The mode register (select 3) uses bit 7 as chain and bit 6 as interrupt-select. Bits 5:0 read back as zero and have no effect. The chain bit of the last slot always reads zero.
- R3: A transfer reads at the source address and then writes at the destination address. Address and direction stay stable while `mem_ready` is low. For a byte transfer (select 4 bit 0 = 0), the written data is the low byte of the read data, zero-extended.
- R4: For a word transfer with an odd source or destination address, `err` pulses for one cycle and no bus access takes place. The counter and the enable bit are unchanged.
- R5: A non-chained transfer decrements the 16-bit counter (select 2). When the new value is zero, the enable bit (select 5 bit 0) clears.
- R6: With interrupt-select at 1, every non-chained transfer pulses both `cpu_irq` and `flag_clr`.
- R7: With interrupt-select at 0, `cpu_irq` pulses only on the transfer that brings the counter to zero, and `flag_clr` never pulses.
- R8: A transfer with the chain bit set leaves its counter and the enable bit alone and pulses neither `cpu_irq` nor `flag_clr`. The next slot's transfer follows at once.
- R9: `done` pulses in the cycle after each accepted write, and at no other time.
- R10: Activations that arrive while the engine is busy are queued and each one is served. An activation that arrives while the enable bit is 0 starts nothing.
- R11: After reset, no bus request is made, the enable bit and all counters read zero, and no output pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 1 | Descriptor slot index |
| cfg_sel | input | 3 | Register select: 0 src, 1 dst, 2 count, 3 mode, 4 size, 5 enable |
| cfg_wdata | input | 24 | Register write data |
| cfg_rdata | output | 24 | Read data for the selected register |
| src_req | input | 1 | Activation pulse from the interrupt source |
| mem_valid | output | 1 | Bus request |
| mem_we | output | 1 | 1 = write phase, 0 = read phase |
| mem_word | output | 1 | 1 = word access, 0 = byte access |
| mem_addr | output | 24 | Bus address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Bus accepts the current phase |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` in the read phase |
| done | output | 1 | Transfer-complete pulse |
| cpu_irq | output | 1 | CPU interrupt request pulse |
| flag_clr | output | 1 | Clear pulse for the activating source flag |
| err | output | 1 | Misaligned word transfer pulse |

## Verification
The collision of interest is a new activation arriving in the same cycle that the idle sequencer takes a queued one, so the pending count is raised and lowered at once. The bench provokes this in two ways. It sends three back-to-back activations starting from idle, and it sends one pulse timed to the idle cycle that follows a `done`. The result is judged by counting the writes and `done`/`cpu_irq` pulses, which must equal the number of activations, and by reading back a counter that must have dropped by exactly that number.

// File: rtl/xfer_pkg.sv
// Shared definitions for the transfer engine: sequencer states, register
// selects and mode bit positions. Assumes nothing beyond IEEE 1800-2017.
package xfer_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHK,
        S_RD,
        S_WR,
        S_FIN
    } seq_state_t;

    localparam logic [2:0] SEL_SRC  = 3'd0;
    localparam logic [2:0] SEL_DST  = 3'd1;
    localparam logic [2:0] SEL_CNT  = 3'd2;
    localparam logic [2:0] SEL_MODE = 3'd3;
    localparam logic [2:0] SEL_SIZE = 3'd4;
    localparam logic [2:0] SEL_EN   = 3'd5;

    localparam int MODE_CHAIN_BIT = 7;
    localparam int MODE_ISEL_BIT  = 6;

endpackage

// File: rtl/xfer_regs.sv
// Descriptor file: one slot per descriptor (addresses, counter, mode, size)
// plus the shared transfer-enable bit. The CPU writes through cfg_*.
// The sequencer updates the current slot's counter and may clear the enable.
// Assumes ADDR_W >= CNT_W and ADDR_W >= 8.
module xfer_regs
    import xfer_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int CNT_W    = 16,
    parameter int NUM_DESC = 2,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic [IDX_W-1:0]  cur_idx,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              cur_chain,
    output logic              cur_isel,
    output logic              cur_word,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_new,
    input  logic              en_clr,
    output logic              en_o
);

    logic [ADDR_W-1:0] src_a   [NUM_DESC];
    logic [ADDR_W-1:0] dst_a   [NUM_DESC];
    logic [CNT_W-1:0]  cnt_a   [NUM_DESC];
    logic              chain_a [NUM_DESC];
    logic              isel_a  [NUM_DESC];
    logic              word_a  [NUM_DESC];
    logic              en_q;

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
        logic [ADDR_W-1:0] src_q;
        logic [ADDR_W-1:0] dst_q;
        logic [CNT_W-1:0]  cnt_q;
        logic              chain_q;
        logic              isel_q;
        logic              word_q;
        logic              hit;

        assign hit = cfg_we && (cfg_idx == IDX_W'(g));

        // Slot storage: CPU writes; a sequencer counter update takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q   <= '0;
                dst_q   <= '0;
                cnt_q   <= '0;
                chain_q <= 1'b0;
                isel_q  <= 1'b0;
                word_q  <= 1'b0;
            end else begin
                if (hit) begin
                    case (cfg_sel)
                        SEL_SRC:  src_q <= cfg_wdata;
                        SEL_DST:  dst_q <= cfg_wdata;
                        SEL_CNT:  cnt_q <= cfg_wdata[CNT_W-1:0];
                        SEL_MODE: begin
                            chain_q <= (g == NUM_DESC - 1) ? 1'b0 : cfg_wdata[MODE_CHAIN_BIT];
                            isel_q  <= cfg_wdata[MODE_ISEL_BIT];
                        end
                        SEL_SIZE: word_q <= cfg_wdata[0];
                        default:  ;
                    endcase
                end
                if (cnt_we && (cur_idx == IDX_W'(g)))
                    cnt_q <= cnt_new;
            end
        end

        assign src_a[g]   = src_q;
        assign dst_a[g]   = dst_q;
        assign cnt_a[g]   = cnt_q;
        assign chain_a[g] = chain_q;
        assign isel_a[g]  = isel_q;
        assign word_a[g]  = word_q;
    end

    // Enable bit: hardware clear at count end wins over a CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_clr)
            en_q <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_EN)
            en_q <= cfg_wdata[0];
    end

    // Readback mux; reserved mode bits return zero.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_SRC:  cfg_rdata = src_a[cfg_idx];
            SEL_DST:  cfg_rdata = dst_a[cfg_idx];
            SEL_CNT:  cfg_rdata = ADDR_W'(cnt_a[cfg_idx]);
            SEL_MODE: begin
                cfg_rdata[MODE_CHAIN_BIT] = chain_a[cfg_idx];
                cfg_rdata[MODE_ISEL_BIT]  = isel_a[cfg_idx];
            end
            SEL_SIZE: cfg_rdata[0] = word_a[cfg_idx];
            SEL_EN:   cfg_rdata[0] = en_q;
            default:  cfg_rdata = '0;
        endcase
    end

    assign cur_src   = src_a[cur_idx];
    assign cur_dst   = dst_a[cur_idx];
    assign cur_cnt   = cnt_a[cur_idx];
    assign cur_chain = chain_a[cur_idx];
    assign cur_isel  = isel_a[cur_idx];
    assign cur_word  = word_a[cur_idx];
    assign en_o      = en_q;

    // R5
    en_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> $past(en_clr || (cfg_we && cfg_sel == SEL_EN)));

endmodule

// File: rtl/xfer_pend.sv
// Pending-activation counter: counts accepted activations not yet taken by
// the sequencer. A push and a pop in the same cycle leave it unchanged.
// Assumes no more than 2**PEND_W-1 activations are outstanding.
module xfer_pend #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic nz
);

    logic [PEND_W-1:0] cnt_q;

    // Up/down count of outstanding activations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push && !pop)
            cnt_q <= cnt_q + 1'b1;
        else if (pop && !push)
            cnt_q <= cnt_q - 1'b1;
    end

    assign nz = (cnt_q != '0);

    // R10
    pend_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (cnt_q != '1));

    // R10
    pend_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

endmodule

// File: rtl/xfer_seq.sv
// Transfer sequencer: alignment check, read phase, write phase, then the
// end-of-transfer decision from the chain and interrupt-select bits.
// Assumes the memory port holds mem_rdata valid while mem_ready is high.
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int NUM_DESC = 2,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              take,
    output logic [IDX_W-1:0]  cur_idx,
    input  logic [ADDR_W-1:0] cur_src,
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic              cur_chain,
    input  logic              cur_isel,
    input  logic              cur_word,
    output logic              cnt_we,
    output logic [CNT_W-1:0]  cnt_new,
    output logic              en_clr,
    output logic              mem_valid,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              cpu_irq,
    output logic              flag_clr,
    output logic              err
);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic              misalign;
    logic              cnt_end;

    assign misalign = cur_word && (cur_src[0] || cur_dst[0]);
    assign cnt_new  = cur_cnt - 1'b1;
    assign cnt_end  = (cnt_new == '0);
    assign cur_idx  = idx_q;
    assign mem_word = cur_word;

    // Per-state outputs and end-of-transfer decisions.
    always_comb begin
        take      = 1'b0;
        err       = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_src;
        mem_wdata = data_q;
        done      = 1'b0;
        cnt_we    = 1'b0;
        cpu_irq   = 1'b0;
        flag_clr  = 1'b0;
        en_clr    = 1'b0;
        case (state_q)
            S_IDLE: take = start;
            S_CHK:  err  = misalign;
            S_RD:   mem_valid = 1'b1;
            S_WR: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_dst;
            end
            S_FIN: begin
                done = 1'b1;
                if (!cur_chain) begin
                    cnt_we   = 1'b1;
                    cpu_irq  = cur_isel || cnt_end;
                    flag_clr = cur_isel;
                    en_clr   = cnt_end;
                end
            end
            default: ;
        endcase
    end

    // State, slot index and captured read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_CHK;
                    idx_q   <= '0;
                end
                S_CHK: state_q <= misalign ? S_IDLE : S_RD;
                S_RD: if (mem_ready) begin
                    data_q  <= cur_word ? mem_rdata
                                        : {{(DATA_W-8){1'b0}}, mem_rdata[7:0]};
                    state_q <= S_WR;
                end
                S_WR: if (mem_ready) state_q <= S_FIN;
                S_FIN: begin
                    if (cur_chain) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= S_CHK;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_valid && mem_we && mem_ready) |-> done);

    // R9
    done_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_valid && mem_we && mem_ready));

    // R3
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R4
    err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !mem_valid);

    // R6
    flag_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |-> (cpu_irq && done));

endmodule

// File: rtl/xfer_ctl.sv
// Top of the interrupt-triggered transfer engine. Joins the descriptor file,
// the pending counter and the sequencer. Activations are accepted only while
// the enable bit is set; every transfer starts at slot 0.
module xfer_ctl #(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int NUM_DESC = 2,
    parameter int PEND_W   = 4,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              src_req,
    output logic              mem_valid,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              cpu_irq,
    output logic              flag_clr,
    output logic              err
);

    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] cur_src;
    logic [ADDR_W-1:0] cur_dst;
    logic [CNT_W-1:0]  cur_cnt;
    logic [CNT_W-1:0]  cnt_new;
    logic cur_chain, cur_isel, cur_word;
    logic cnt_we, en_clr, en;
    logic pend_nz, take;

    xfer_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_DESC(NUM_DESC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cur_idx(cur_idx), .cur_src(cur_src), .cur_dst(cur_dst),
        .cur_cnt(cur_cnt), .cur_chain(cur_chain), .cur_isel(cur_isel),
        .cur_word(cur_word), .cnt_we(cnt_we), .cnt_new(cnt_new),
        .en_clr(en_clr), .en_o(en)
    );

    xfer_pend #(
        .PEND_W(PEND_W)
    ) u_pend (
        .clk(clk), .rst_n(rst_n),
        .push(src_req && en), .pop(take), .nz(pend_nz)
    );

    xfer_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_DESC(NUM_DESC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(pend_nz), .take(take), .cur_idx(cur_idx),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt),
        .cur_chain(cur_chain), .cur_isel(cur_isel), .cur_word(cur_word),
        .cnt_we(cnt_we), .cnt_new(cnt_new), .en_clr(en_clr),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .cpu_irq(cpu_irq), .flag_clr(flag_clr), .err(err)
    );

    // R8
    chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_chain) |-> (!cpu_irq && !flag_clr && !en_clr));

endmodule

// File: tb/xfer_ctl_tb.sv
// Directed bench for xfer_ctl: one task per scenario, each checking itself.
module xfer_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic [2:0]  cfg_sel = '0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        src_req = 1'b0;
    logic        mem_valid, mem_we, mem_word;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ready;
    logic [15:0] mem_rdata;
    logic        done, cpu_irq, flag_clr, err;
    logic        stall = 1'b0;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    assign mem_ready = mem_valid && !stall;
    assign mem_rdata = mem_addr[15:0] ^ 16'h5A3C;

    xfer_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .src_req(src_req),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .done(done), .cpu_irq(cpu_irq), .flag_clr(flag_clr), .err(err)
    );

    // Bus and pulse monitor.
    int wr_n = 0, rd_n = 0, done_n = 0, irq_n = 0, fc_n = 0, err_n = 0;
    int cyc = 0, wr_cyc = -10, gap_bad = 0;
    logic [23:0] last_wa;
    logic [15:0] last_wd;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (mem_valid && mem_ready && mem_we) begin
                wr_n <= wr_n + 1; last_wa <= mem_addr; last_wd <= mem_wdata; wr_cyc <= cyc;
            end
            if (mem_valid && mem_ready && !mem_we) rd_n <= rd_n + 1;
            if (done) begin
                done_n <= done_n + 1;
                if (wr_cyc != cyc - 1) gap_bad <= gap_bad + 1;
            end
            if (cpu_irq)  irq_n <= irq_n + 1;
            if (flag_clr) fc_n  <= fc_n + 1;
            if (err)      err_n <= err_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic idx, input logic [2:0] sel, input logic [23:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic idx, input logic [2:0] sel, output logic [23:0] val);
        @(negedge clk);
        cfg_idx = idx; cfg_sel = sel;
        #1 val = cfg_rdata;
    endtask

    task automatic fire();
        @(negedge clk); src_req = 1'b1;
        @(negedge clk); src_req = 1'b0;
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [23:0] v;
        @(negedge clk);
        chk("R11 mem_valid", mem_valid, 0);
        chk("R11 pulses", {done, cpu_irq, flag_clr, err}, 0);
        rd_reg(0, 3'd5, v); chk("R11 enable", v, 0);
        rd_reg(0, 3'd2, v); chk("R11 count0", v, 0);
        rd_reg(1, 3'd2, v); chk("R11 count1", v, 0);
    endtask

    task automatic t_regs();
        logic [23:0] v;
        wr_reg(0, 3'd0, 24'hABCDEF); rd_reg(0, 3'd0, v); chk("R1 src", v, 24'hABCDEF);
        wr_reg(1, 3'd1, 24'hF01235); rd_reg(1, 3'd1, v); chk("R1 dst", v, 24'hF01235);
        wr_reg(0, 3'd3, 24'h0000FF); rd_reg(0, 3'd3, v); chk("R2 mode slot0", v, 24'hC0);
        wr_reg(1, 3'd3, 24'h0000FF); rd_reg(1, 3'd3, v); chk("R2 mode last slot", v, 24'h40);
        wr_reg(1, 3'd3, 24'h00003F); rd_reg(1, 3'd3, v); chk("R2 reserved only", v, 24'h0);
    endtask

    task automatic t_byte_isel();
        logic [23:0] v;
        int w0, i0, f0;
        wr_reg(0, 3'd0, 24'h000101); wr_reg(0, 3'd1, 24'h000203);
        wr_reg(0, 3'd2, 24'd3); wr_reg(0, 3'd3, 24'h7F);
        wr_reg(0, 3'd4, 24'd0); wr_reg(0, 3'd5, 24'd1);
        w0 = wr_n; i0 = irq_n; f0 = fc_n;
        fire(); settle();
        chk("R3 one write", wr_n - w0, 1);
        chk("R3 dst addr", last_wa, 24'h000203);
        chk("R3 byte data", last_wd, 16'h003D);
        chk("R6 irq", irq_n - i0, 1);
        chk("R6 flag_clr", fc_n - f0, 1);
        rd_reg(0, 3'd2, v); chk("R5 count dec", v, 2);
        rd_reg(0, 3'd5, v); chk("R5 enable kept", v, 1);
    endtask

    task automatic t_count_end();
        logic [23:0] v;
        int w0, i0, f0;
        wr_reg(0, 3'd0, 24'h000400); wr_reg(0, 3'd1, 24'h000500);
        wr_reg(0, 3'd2, 24'd2); wr_reg(0, 3'd3, 24'h00);
        wr_reg(0, 3'd4, 24'd1); wr_reg(0, 3'd5, 24'd1);
        w0 = wr_n; i0 = irq_n; f0 = fc_n;
        fire(); settle();
        chk("R7 no irq before end", irq_n - i0, 0);
        rd_reg(0, 3'd2, v); chk("R5 count 1", v, 1);
        fire(); settle();
        chk("R7 irq at end", irq_n - i0, 1);
        chk("R7 no flag_clr", fc_n - f0, 0);
        chk("R3 word data", last_wd, 16'h5E3C);
        rd_reg(0, 3'd5, v); chk("R5 enable cleared", v, 0);
        rd_reg(0, 3'd2, v); chk("R5 count 0", v, 0);
        fire(); settle();
        chk("R10 disabled ignored", wr_n - w0, 2);
    endtask

    task automatic t_misalign();
        logic [23:0] v;
        int w0, r0, e0, i0;
        wr_reg(0, 3'd0, 24'h000101); wr_reg(0, 3'd1, 24'h000200);
        wr_reg(0, 3'd2, 24'd7); wr_reg(0, 3'd3, 24'h40);
        wr_reg(0, 3'd4, 24'd1); wr_reg(0, 3'd5, 24'd1);
        w0 = wr_n; r0 = rd_n; e0 = err_n; i0 = irq_n;
        fire(); settle();
        chk("R4 err pulse", err_n - e0, 1);
        chk("R4 no bus", (wr_n - w0) + (rd_n - r0), 0);
        chk("R4 no irq", irq_n - i0, 0);
        rd_reg(0, 3'd2, v); chk("R4 count kept", v, 7);
        rd_reg(0, 3'd5, v); chk("R4 enable kept", v, 1);
    endtask

    task automatic t_chain();
        logic [23:0] v;
        int w0, i0, f0;
        wr_reg(0, 3'd0, 24'h000010); wr_reg(0, 3'd1, 24'h000020);
        wr_reg(0, 3'd2, 24'd5); wr_reg(0, 3'd3, 24'hC0); wr_reg(0, 3'd4, 24'd1);
        wr_reg(1, 3'd0, 24'h000030); wr_reg(1, 3'd1, 24'h000040);
        wr_reg(1, 3'd2, 24'd1); wr_reg(1, 3'd3, 24'h00); wr_reg(1, 3'd4, 24'd0);
        wr_reg(0, 3'd5, 24'd1);
        w0 = wr_n; i0 = irq_n; f0 = fc_n;
        fire(); settle();
        chk("R8 two writes", wr_n - w0, 2);
        chk("R8 second dst", last_wa, 24'h000040);
        chk("R8 second data", last_wd, 16'h000C);
        chk("R8 irq only from end", irq_n - i0, 1);
        chk("R8 no flag_clr", fc_n - f0, 0);
        rd_reg(0, 3'd2, v); chk("R8 chained count kept", v, 5);
        rd_reg(1, 3'd2, v); chk("R8 slot1 count", v, 0);
        rd_reg(0, 3'd5, v); chk("R8 enable cleared by slot1", v, 0);
    endtask

    task automatic t_pending();
        logic [23:0] v;
        int w0, d0, i0;
        wr_reg(0, 3'd0, 24'h000008); wr_reg(0, 3'd1, 24'h000009);
        wr_reg(0, 3'd2, 24'd100); wr_reg(0, 3'd3, 24'h40);
        wr_reg(0, 3'd4, 24'd0); wr_reg(0, 3'd5, 24'd1);
        w0 = wr_n; d0 = done_n; i0 = irq_n;
        stall = 1'b1;
        @(negedge clk); src_req = 1'b1;
        repeat (3) @(negedge clk);
        src_req = 1'b0;
        repeat (8) @(negedge clk);
        stall = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk); src_req = 1'b1;
        @(negedge clk); src_req = 1'b0;
        repeat (60) @(negedge clk);
        chk("R10 all writes", wr_n - w0, 4);
        chk("R10 all done", done_n - d0, 4);
        chk("R6 irq per transfer", irq_n - i0, 4);
        rd_reg(0, 3'd2, v); chk("R10 count", v, 96);
        chk("R9 done timing", gap_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_byte_isel();
        t_count_end();
        t_misalign();
        t_chain();
        t_pending();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule